// File: doc/BRIEF.md
# Calendar Clock with Alarm

This block keeps a calendar time made of seconds, minutes, hours, day of week, day of month, month and a two-digit year. It holds the time internally in plain binary and shows it on seven byte-wide outputs, encoded either as packed BCD or as binary. Hours are shown either in 24-hour form or in 12-hour form with a PM flag. A pulse on the one-second tick input moves the time forward by one second, but only while the three-bit divider field carries the normal-operation code.

Each accepted second opens an update window of a fixed number of clock cycles, during which the update-in-progress output is high. When the window closes, the visible bytes are rewritten from the internal time. At the same moment the alarm comparison and the update-ended condition are evaluated, and a one-cycle flag pulse reports which interrupt-flag bits the host's status register should OR in. A host writes time and alarm bytes through a single field-write port. A SET control freezes the visible bytes so that the host can load a complete new time, which is taken over when SET drops.

Top module: `cal_clock`

## Requirements
- R1: After reset, every visible time byte reads 0x00 except day of month and month, which read 0x01. `uip_o` and `flag_set_o` are 0, and all three alarm bytes are 0x00.
- R2: A `tick_1hz` pulse is accepted only when `div_sel` equals 3'b010. With any other value the tick has no effect: `uip_o` stays low, no flag is raised and the time does not advance.
- R3: Seconds and minutes wrap from 59 to 0, and hours wrap from 23 to 0, each carrying into the next field. Day of week runs 0..6 and wraps to 0. At the day rollover, a day of month at or beyond the month's length becomes 1 and carries into the month. Month 12 wraps to 1 and carries into the year, and year 99 wraps to 0. A month value outside 1..12 is treated as 31 days long.
- R4: February has 29 days when 2000 + year is divisible by 4 and either not divisible by 100 or divisible by 400. Otherwise it has 28 days. April, June, September and November have 30 days, and all other months have 31.
- R5: `bin_mode`=1 shows and loads fields as binary. `bin_mode`=0 uses packed BCD, with the tens digit in bits 7..4 and the units digit in bits 3..0.
- R6: With `h24_mode`=0 the hour byte shows hour mod 12, with bit 7 set for hours 12..23. On a load, bit 7 adds 12 to the value held in bits 6..0. With `h24_mode`=1 the hour is shown as 0..23 and bit 7 is ignored on a load.
- R7: An accepted tick raises `uip_o` at the next clock edge, unless SET is active, and `uip_o` stays high for exactly UIP_CYCLES cycles. The visible bytes are refreshed at the edge where `uip_o` falls. Ticks that arrive during the window are ignored.
- R8: While `set_mode`=1, `uip_o` is held low, the visible bytes are not refreshed, and no update-ended flag is raised. The internal time keeps counting.
- R9: `wr_sel` selects the field: 0 seconds, 1 minutes, 2 hours, 3 day of week, 4 day of month, 5 month, 6 year, 8 seconds alarm, 9 minutes alarm, 10 hours alarm. A time-field write always updates the visible byte. If `set_mode`=0, the internal time is also reloaded from all visible bytes at once. A falling `set_mode` reloads the internal time from the visible bytes.
- R10: With `alarm_ie`=1, the alarm matches when each of the seconds, minutes and hours alarm bytes either has bits 7..6 equal to 11 or decodes (R5) to the current field value. A match ORs 0xA0 into the flag pulse at the end of the window.
- R11: With `upd_ie`=1 and SET clear, each completed window ORs 0x90 into the flag pulse. `flag_set_o` is nonzero for exactly one cycle per window, and only bits 7, 5 and 4 can be set.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| tick_1hz | input | 1 | One-second tick, one cycle wide |
| div_sel | input | 3 | Divider field; 3'b010 means normal operation |
| set_mode | input | 1 | SET: freezes the visible bytes for host loading |
| bin_mode | input | 1 | 1 = binary, 0 = packed BCD |
| h24_mode | input | 1 | 1 = 24-hour, 0 = 12-hour with PM bit 7 |
| alarm_ie | input | 1 | Alarm flag enable |
| upd_ie | input | 1 | Update-ended flag enable |
| wr_en | input | 1 | Field write strobe |
| wr_sel | input | 4 | Field select (see R9) |
| wr_data | input | 8 | Field write data |
| sec_o | output | 8 | Visible seconds |
| min_o | output | 8 | Visible minutes |
| hour_o | output | 8 | Visible hours |
| wday_o | output | 8 | Visible day of week |
| mday_o | output | 8 | Visible day of month |
| mon_o | output | 8 | Visible month |
| year_o | output | 8 | Visible two-digit year |
| uip_o | output | 1 | Update in progress |
| flag_set_o | output | 8 | One-cycle pulse of the flag bits to OR into the status register |

## Verification
The assertions check on every cycle that SET holds update-in-progress low and that the update window never runs longer than its configured length. They also check that a tick given under a stopped divider does not open a window, that the flag pulse lasts one cycle and uses only the allowed bits, and that the seconds byte changes only after a write or at the end of a window.

Only the bench's scenarios can show the calendar arithmetic: carries across the year end, the leap-year February cases, and the 12-hour and BCD encodings. The same holds for taking over a new time when SET drops and for alarm matching with don't-care fields, which the bench drives both as directed cases and as seeded random times.

// File: rtl/cal_pkg.sv
package cal_pkg;

    typedef struct packed {
        logic [7:0] sec;
        logic [7:0] min;
        logic [7:0] hour;
        logic [7:0] wday;
        logic [7:0] mday;
        logic [7:0] mon;
        logic [7:0] year;
    } cal_time_t;

    localparam int NUM_ALARM = 3;
    localparam logic [2:0] DIV_NORMAL = 3'b010;
    localparam logic [7:0] FLG_ALARM = 8'hA0;
    localparam logic [7:0] FLG_UPD   = 8'h90;

    localparam logic [3:0] SEL_SEC   = 4'd0;
    localparam logic [3:0] SEL_MIN   = 4'd1;
    localparam logic [3:0] SEL_HOUR  = 4'd2;
    localparam logic [3:0] SEL_WDAY  = 4'd3;
    localparam logic [3:0] SEL_MDAY  = 4'd4;
    localparam logic [3:0] SEL_MON   = 4'd5;
    localparam logic [3:0] SEL_YEAR  = 4'd6;
    localparam logic [3:0] SEL_ASEC  = 4'd8;
    localparam logic [3:0] SEL_AMIN  = 4'd9;
    localparam logic [3:0] SEL_AHOUR = 4'd10;

    function automatic logic [7:0] enc_val(input logic [7:0] v, input logic bin);
        logic [7:0] tens;
        logic [7:0] ones;
        tens = v / 8'd10;
        ones = v % 8'd10;
        return bin ? v : {tens[3:0], ones[3:0]};
    endfunction

    function automatic logic [7:0] dec_val(input logic [7:0] b, input logic bin);
        logic [7:0] hi;
        logic [7:0] lo;
        hi = {4'd0, b[7:4]};
        lo = {4'd0, b[3:0]};
        return bin ? b : 8'(hi * 8'd10 + lo);
    endfunction

    function automatic logic [7:0] enc_hour(input logic [7:0] h, input logic bin, input logic h24);
        logic [7:0] pm;
        pm = (h >= 8'd12) ? 8'h80 : 8'h00;
        return h24 ? enc_val(h, bin) : (enc_val(h % 8'd12, bin) | pm);
    endfunction

    function automatic logic [7:0] dec_hour(input logic [7:0] b, input logic bin, input logic h24);
        logic [7:0] add;
        add = (!h24 && b[7]) ? 8'd12 : 8'd0;
        return 8'(dec_val({1'b0, b[6:0]}, bin) + add);
    endfunction

    function automatic logic is_leap(input logic [7:0] yy);
        logic [11:0] y;
        y = 12'd2000 + {4'd0, yy};
        return ((y % 12'd4) == 12'd0) &&
               (((y % 12'd100) != 12'd0) || ((y % 12'd400) == 12'd0));
    endfunction

    function automatic logic [7:0] month_len(input logic [7:0] mon, input logic [7:0] yy);
        logic [7:0] d;
        case (mon)
            8'd2:                      d = is_leap(yy) ? 8'd29 : 8'd28;
            8'd4, 8'd6, 8'd9, 8'd11:   d = 8'd30;
            default:                   d = 8'd31;
        endcase
        return d;
    endfunction

    function automatic cal_time_t encode_time(input cal_time_t t, input logic bin, input logic h24);
        cal_time_t v;
        v.sec  = enc_val(t.sec, bin);
        v.min  = enc_val(t.min, bin);
        v.hour = enc_hour(t.hour, bin, h24);
        v.wday = enc_val(t.wday, bin);
        v.mday = enc_val(t.mday, bin);
        v.mon  = enc_val(t.mon, bin);
        v.year = enc_val(t.year, bin);
        return v;
    endfunction

    function automatic cal_time_t decode_time(input cal_time_t v, input logic bin, input logic h24);
        cal_time_t t;
        t.sec  = dec_val(v.sec, bin);
        t.min  = dec_val(v.min, bin);
        t.hour = dec_hour(v.hour, bin, h24);
        t.wday = dec_val(v.wday, bin);
        t.mday = dec_val(v.mday, bin);
        t.mon  = dec_val(v.mon, bin);
        t.year = dec_val(v.year, bin);
        return t;
    endfunction

endpackage

// File: rtl/cal_step.sv
module cal_step
    import cal_pkg::*;
(
    input  cal_time_t cur,
    output cal_time_t nxt
);
    logic [7:0] days;

    assign days = month_len(cur.mon, cur.year);

    always_comb begin
        nxt = cur;
        if (cur.sec >= 8'd59) begin
            nxt.sec = 8'd0;
            if (cur.min >= 8'd59) begin
                nxt.min = 8'd0;
                if (cur.hour >= 8'd23) begin
                    nxt.hour = 8'd0;
                    nxt.wday = (cur.wday >= 8'd6) ? 8'd0 : cur.wday + 8'd1;
                    if (cur.mday >= days) begin
                        nxt.mday = 8'd1;
                        if (cur.mon >= 8'd12) begin
                            nxt.mon  = 8'd1;
                            nxt.year = (cur.year >= 8'd99) ? 8'd0 : cur.year + 8'd1;
                        end else begin
                            nxt.mon = cur.mon + 8'd1;
                        end
                    end else begin
                        nxt.mday = cur.mday + 8'd1;
                    end
                end else begin
                    nxt.hour = cur.hour + 8'd1;
                end
            end else begin
                nxt.min = cur.min + 8'd1;
            end
        end else begin
            nxt.sec = cur.sec + 8'd1;
        end
    end
endmodule

// File: rtl/cal_alarm.sv
module cal_alarm
    import cal_pkg::*;
#(
    parameter int NUM_FLD = NUM_ALARM
) (
    input  logic [NUM_FLD-1:0][7:0] alm,
    input  logic [NUM_FLD-1:0][7:0] cur,
    input  logic                    bin,
    output logic                    hit
);
    logic [NUM_FLD-1:0] fld_hit;

    for (genvar i = 0; i < NUM_FLD; i++) begin : g_fld
        assign fld_hit[i] = (alm[i][7:6] == 2'b11) || (dec_val(alm[i], bin) == cur[i]);
    end

    assign hit = &fld_hit;
endmodule

// File: rtl/cal_seq.sv
module cal_seq #(
    parameter int UIP_CYCLES = 8
) (
    input  logic clk,
    input  logic rst,
    input  logic tick,
    input  logic div_ok,
    output logic accept,
    output logic fin
);
    localparam int CW = $clog2(UIP_CYCLES + 1);

    logic          busy_q;
    logic [CW-1:0] cnt_q;

    assign accept = tick && div_ok && !busy_q;
    assign fin    = busy_q && (cnt_q == '0);

    always_ff @(posedge clk) begin
        if (rst) begin
            busy_q <= 1'b0;
            cnt_q  <= '0;
        end else if (accept) begin
            busy_q <= 1'b1;
            cnt_q  <= CW'(UIP_CYCLES - 1);
        end else if (fin) begin
            busy_q <= 1'b0;
        end else if (busy_q) begin
            cnt_q  <= cnt_q - 1'b1;
        end
    end
endmodule

// File: rtl/cal_clock.sv
module cal_clock
    import cal_pkg::*;
#(
    parameter int UIP_CYCLES = 8
) (
    input  logic       clk,
    input  logic       rst,
    input  logic       tick_1hz,
    input  logic [2:0] div_sel,
    input  logic       set_mode,
    input  logic       bin_mode,
    input  logic       h24_mode,
    input  logic       alarm_ie,
    input  logic       upd_ie,
    input  logic       wr_en,
    input  logic [3:0] wr_sel,
    input  logic [7:0] wr_data,
    output logic [7:0] sec_o,
    output logic [7:0] min_o,
    output logic [7:0] hour_o,
    output logic [7:0] wday_o,
    output logic [7:0] mday_o,
    output logic [7:0] mon_o,
    output logic [7:0] year_o,
    output logic       uip_o,
    output logic [7:0] flag_set_o
);
    localparam cal_time_t RESET_TIME = '{sec: 8'd0, min: 8'd0, hour: 8'd0, wday: 8'd0,
                                          mday: 8'd1, mon: 8'd1, year: 8'd0};

    cal_time_t time_q, time_nxt, step_out;
    cal_time_t vis_q, vis_nxt;
    logic [NUM_ALARM-1:0][7:0] alm_q, alm_nxt;
    logic [NUM_ALARM-1:0][7:0] cur_al;
    logic accept, fin, alarm_hit;
    logic set_q, set_fall, time_wr, uip_q;
    logic [7:0] flag_q;

    cal_seq #(.UIP_CYCLES(UIP_CYCLES)) u_seq (
        .clk(clk), .rst(rst), .tick(tick_1hz),
        .div_ok(div_sel == DIV_NORMAL), .accept(accept), .fin(fin)
    );

    cal_step u_step (.cur(time_q), .nxt(step_out));

    assign cur_al = {time_q.hour, time_q.min, time_q.sec};

    cal_alarm #(.NUM_FLD(NUM_ALARM)) u_alarm (
        .alm(alm_q), .cur(cur_al), .bin(bin_mode), .hit(alarm_hit)
    );

    assign set_fall = set_q && !set_mode;
    assign time_wr  = wr_en && (wr_sel <= SEL_YEAR);

    // visible bytes: refresh at window end, then host write on top
    always_comb begin
        vis_nxt = vis_q;
        alm_nxt = alm_q;
        if (fin && !set_mode)
            vis_nxt = encode_time(time_q, bin_mode, h24_mode);
        if (wr_en) begin
            case (wr_sel)
                SEL_SEC:   vis_nxt.sec  = wr_data;
                SEL_MIN:   vis_nxt.min  = wr_data;
                SEL_HOUR:  vis_nxt.hour = wr_data;
                SEL_WDAY:  vis_nxt.wday = wr_data;
                SEL_MDAY:  vis_nxt.mday = wr_data;
                SEL_MON:   vis_nxt.mon  = wr_data;
                SEL_YEAR:  vis_nxt.year = wr_data;
                SEL_ASEC:  alm_nxt[0]   = wr_data;
                SEL_AMIN:  alm_nxt[1]   = wr_data;
                SEL_AHOUR: alm_nxt[2]   = wr_data;
                default: ;
            endcase
        end
    end

    // internal binary time: reload beats advance
    always_comb begin
        time_nxt = time_q;
        if (accept)
            time_nxt = step_out;
        if ((time_wr && !set_mode) || set_fall)
            time_nxt = decode_time(vis_nxt, bin_mode, h24_mode);
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            time_q <= RESET_TIME;
            vis_q  <= RESET_TIME;
            alm_q  <= '0;
            set_q  <= 1'b0;
            uip_q  <= 1'b0;
            flag_q <= 8'h00;
        end else begin
            time_q <= time_nxt;
            vis_q  <= vis_nxt;
            alm_q  <= alm_nxt;
            set_q  <= set_mode;
            if (set_mode)
                uip_q <= 1'b0;
            else if (accept)
                uip_q <= 1'b1;
            else if (fin)
                uip_q <= 1'b0;
            if (fin)
                flag_q <= ((alarm_ie && alarm_hit) ? FLG_ALARM : 8'h00) |
                          ((upd_ie && !set_mode) ? FLG_UPD : 8'h00);
            else
                flag_q <= 8'h00;
        end
    end

    assign sec_o      = vis_q.sec;
    assign min_o      = vis_q.min;
    assign hour_o     = vis_q.hour;
    assign wday_o     = vis_q.wday;
    assign mday_o     = vis_q.mday;
    assign mon_o      = vis_q.mon;
    assign year_o     = vis_q.year;
    assign uip_o      = uip_q;
    assign flag_set_o = flag_q;
endmodule

// File: rtl/cal_clock_chk.sv
module cal_clock_chk #(
    parameter int UIP_CYCLES = 8
) (
    input logic       clk,
    input logic       rst,
    input logic       tick_1hz,
    input logic [2:0] div_sel,
    input logic       set_mode,
    input logic       wr_en,
    input logic [3:0] wr_sel,
    input logic [7:0] sec_o,
    input logic       uip_o,
    input logic [7:0] flag_set_o
);
    int unsigned uip_run;

    always_ff @(posedge clk) begin
        if (rst)        uip_run <= 0;
        else if (uip_o) uip_run <= uip_run + 1;
        else            uip_run <= 0;
    end

    // R8
    set_uip_chk: assert property (@(posedge clk) disable iff (rst)
        set_mode |=> !uip_o);

    // R7
    uip_len_chk: assert property (@(posedge clk) disable iff (rst)
        uip_o |-> (uip_run < UIP_CYCLES));

    // R2
    div_hold_chk: assert property (@(posedge clk) disable iff (rst)
        (tick_1hz && (div_sel != 3'b010) && !uip_o) |=> !uip_o);

    // R11
    flag_pulse_chk: assert property (@(posedge clk) disable iff (rst)
        (flag_set_o != 8'h00) |=> (flag_set_o == 8'h00));

    // R11
    flag_bits_chk: assert property (@(posedge clk) disable iff (rst)
        (flag_set_o & 8'h4F) == 8'h00);

    // R9
    sec_src_chk: assert property (@(posedge clk) disable iff (rst)
        !$stable(sec_o) |-> (($past(wr_en) && ($past(wr_sel) == 4'd0)) || $fell(uip_o)));
endmodule

bind cal_clock cal_clock_chk #(.UIP_CYCLES(UIP_CYCLES)) u_chk (
    .clk(clk), .rst(rst), .tick_1hz(tick_1hz), .div_sel(div_sel),
    .set_mode(set_mode), .wr_en(wr_en), .wr_sel(wr_sel), .sec_o(sec_o),
    .uip_o(uip_o), .flag_set_o(flag_set_o)
);

// File: tb/cal_clock_test.sv
module cal_clock_test;
    localparam int UIP = 8;

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic tick_1hz = 1'b0;
    logic [2:0] div_sel = 3'b010;
    logic set_mode = 1'b0, bin_mode = 1'b1, h24_mode = 1'b1;
    logic alarm_ie = 1'b0, upd_ie = 1'b0;
    logic wr_en = 1'b0;
    logic [3:0] wr_sel = 4'd0;
    logic [7:0] wr_data = 8'd0;
    logic [7:0] sec_o, min_o, hour_o, wday_o, mday_o, mon_o, year_o, flag_set_o;
    logic uip_o;

    int total = 0, fails = 0, flag_cnt = 0;
    logic [7:0] flag_acc = 8'h00;
    bit done = 1'b0;
    int ms, mn, mh, mw, md, mo, my;

    always #2.5 clk = ~clk;

    cal_clock #(.UIP_CYCLES(UIP)) uut (
        .clk(clk), .rst(rst), .tick_1hz(tick_1hz), .div_sel(div_sel),
        .set_mode(set_mode), .bin_mode(bin_mode), .h24_mode(h24_mode),
        .alarm_ie(alarm_ie), .upd_ie(upd_ie), .wr_en(wr_en), .wr_sel(wr_sel),
        .wr_data(wr_data), .sec_o(sec_o), .min_o(min_o), .hour_o(hour_o),
        .wday_o(wday_o), .mday_o(mday_o), .mon_o(mon_o), .year_o(year_o),
        .uip_o(uip_o), .flag_set_o(flag_set_o)
    );

    always @(negedge clk) begin
        if (flag_set_o != 8'h00) begin
            flag_acc = flag_acc | flag_set_o;
            flag_cnt++;
        end
    end

    function automatic logic [7:0] benc(input int v);
        return bin_mode ? 8'(v) : 8'(((v / 10) << 4) | (v % 10));
    endfunction

    function automatic logic [7:0] bhour(input int h);
        if (h24_mode) return benc(h);
        return benc(h % 12) | ((h >= 12) ? 8'h80 : 8'h00);
    endfunction

    function automatic int bdim(input int m, input int yy);
        int y;
        y = 2000 + yy;
        if (m == 2) return (((y % 4) == 0) && (((y % 100) != 0) || ((y % 400) == 0))) ? 29 : 28;
        if (m == 4 || m == 6 || m == 9 || m == 11) return 30;
        return 31;
    endfunction

    task automatic mstep();
        ms++;
        if (ms == 60) begin
            ms = 0; mn++;
            if (mn == 60) begin
                mn = 0; mh++;
                if (mh == 24) begin
                    mh = 0;
                    mw = (mw + 1) % 7;
                    md++;
                    if (md > bdim(mo, my)) begin
                        md = 1; mo++;
                        if (mo > 12) begin mo = 1; my = (my + 1) % 100; end
                    end
                end
            end
        end
    endtask

    task automatic chk(input string req, input logic [7:0] act, input logic [7:0] exp);
        total++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic wr(input logic [3:0] s, input logic [7:0] d);
        @(negedge clk);
        wr_en = 1'b1; wr_sel = s; wr_data = d;
        @(negedge clk);
        wr_en = 1'b0;
    endtask

    task automatic load(input int s, input int m, input int h, input int w,
                        input int d, input int mth, input int y);
        ms = s; mn = m; mh = h; mw = w; md = d; mo = mth; my = y;
        wr(4'd0, benc(s)); wr(4'd1, benc(m)); wr(4'd2, bhour(h));
        wr(4'd3, benc(w)); wr(4'd4, benc(d)); wr(4'd5, benc(mth)); wr(4'd6, benc(y));
    endtask

    task automatic check_time(input string req);
        chk({req, " sec"},  sec_o,  benc(ms));
        chk({req, " min"},  min_o,  benc(mn));
        chk({req, " hour"}, hour_o, bhour(mh));
        chk({req, " wday"}, wday_o, benc(mw));
        chk({req, " mday"}, mday_o, benc(md));
        chk({req, " mon"},  mon_o,  benc(mo));
        chk({req, " year"}, year_o, benc(my));
    endtask

    // one tick; checks the update window shape (R7)
    task automatic tick_run(input bit exp_uip);
        flag_acc = 8'h00; flag_cnt = 0;
        @(negedge clk); tick_1hz = 1'b1;
        @(negedge clk); tick_1hz = 1'b0;
        chk("R7 uip rise", {7'd0, uip_o}, {7'd0, exp_uip});
        repeat (UIP - 1) @(negedge clk);
        chk("R7 uip held", {7'd0, uip_o}, {7'd0, exp_uip});
        @(negedge clk);
        chk("R7 uip end", {7'd0, uip_o}, 8'd0);
        repeat (2) @(negedge clk);
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            fails++; total++;
            $display("FAIL watchdog actual=hung expected=done");
            $display("%0d/%0d checks passed", total - fails, total);
            $finish;
        end
    end

    initial begin
        void'($urandom(32'd4242));
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        // R1 reset state
        ms = 0; mn = 0; mh = 0; mw = 0; md = 1; mo = 1; my = 0;
        check_time("R1");
        chk("R1 uip", {7'd0, uip_o}, 8'd0);
        chk("R1 flag", flag_set_o, 8'd0);

        // R3 plain advance, binary 24h
        tick_run(1'b1); mstep(); check_time("R3 first second");

        // R3 full year carry
        load(59, 59, 23, 6, 31, 12, 99);
        tick_run(1'b1); mstep(); check_time("R3 year wrap");
        chk("R3 year zero", year_o, 8'd0);

        // R3 out-of-range month treated as 31 days
        load(59, 59, 23, 2, 30, 13, 5);
        tick_run(1'b1); mstep(); check_time("R3 month13");
        chk("R3 month13 mday", mday_o, 8'd31);

        // R4 leap cases
        load(59, 59, 23, 1, 28, 2, 24);
        tick_run(1'b1); mstep(); chk("R4 2024 feb29", mday_o, 8'd29);
        load(59, 59, 23, 1, 28, 2, 23);
        tick_run(1'b1); mstep(); chk("R4 2023 mar", mon_o, 8'd3);
        load(59, 59, 23, 1, 28, 2, 0);
        tick_run(1'b1); mstep(); chk("R4 2000 feb29", mday_o, 8'd29);
        load(59, 59, 23, 1, 30, 4, 10);
        tick_run(1'b1); mstep(); check_time("R4 april30");

        // R5 BCD
        bin_mode = 1'b0;
        load(59, 59, 9, 3, 15, 7, 45);
        tick_run(1'b1); mstep(); check_time("R5 bcd");
        chk("R5 bcd hour 10", hour_o, 8'h10);

        // R6 12-hour
        h24_mode = 1'b0;
        load(59, 59, 11, 3, 15, 7, 45);
        tick_run(1'b1); mstep(); chk("R6 noon", hour_o, 8'h80);
        load(59, 59, 23, 3, 15, 7, 45);
        chk("R6 pm load", hour_o, 8'h91);
        tick_run(1'b1); mstep(); check_time("R6 midnight");
        load(10, 0, 13, 3, 15, 7, 45);
        tick_run(1'b1); mstep(); chk("R6 13h", hour_o, 8'h81);
        h24_mode = 1'b1; bin_mode = 1'b1;

        // R2 stopped divider
        load(30, 20, 10, 2, 5, 5, 20);
        div_sel = 3'b000; tick_run(1'b0); check_time("R2 div 000");
        div_sel = 3'b110; tick_run(1'b0); check_time("R2 div 110");
        chk("R2 no flag", flag_acc, 8'h00);
        div_sel = 3'b010;

        // R7 tick during window ignored
        flag_acc = 8'h00;
        @(negedge clk); tick_1hz = 1'b1;
        @(negedge clk); tick_1hz = 1'b0;
        repeat (3) @(negedge clk); tick_1hz = 1'b1;
        @(negedge clk); tick_1hz = 1'b0;
        repeat (UIP + 4) @(negedge clk);
        mstep(); check_time("R7 extra tick");
        chk("R7 uip idle", {7'd0, uip_o}, 8'd0);

        // R8 / R9 SET mode
        upd_ie = 1'b1;
        load(30, 20, 10, 2, 5, 5, 20);
        @(negedge clk); set_mode = 1'b1;
        tick_run(1'b0);
        check_time("R8 frozen");
        chk("R8 no upd flag", flag_acc, 8'h00);
        wr(4'd0, 8'd5);
        chk("R9 set write visible", sec_o, 8'd5);
        @(negedge clk); set_mode = 1'b0;
        @(negedge clk);
        ms = 5;
        tick_run(1'b1); mstep(); check_time("R9 set release reload");
        chk("R11 upd flag", flag_acc, 8'h90);
        chk("R11 one pulse", 8'(flag_cnt), 8'd1);
        wr(4'd0, 8'd40); ms = 40;
        tick_run(1'b1); mstep(); chk("R9 direct reload", sec_o, 8'd41);
        upd_ie = 1'b0;

        // R10 alarm
        alarm_ie = 1'b1;
        load(29, 15, 8, 1, 1, 1, 1);
        wr(4'd8, 8'd30); wr(4'd9, 8'd15); wr(4'd10, 8'd8);
        tick_run(1'b1); mstep(); chk("R10 exact", flag_acc, 8'hA0);
        wr(4'd8, 8'hC0); wr(4'd10, 8'hFF);
        tick_run(1'b1); mstep(); chk("R10 dont care", flag_acc, 8'hA0);
        wr(4'd9, 8'd16);
        tick_run(1'b1); mstep(); chk("R10 mismatch", flag_acc, 8'h00);
        wr(4'd9, 8'd15); upd_ie = 1'b1;
        tick_run(1'b1); mstep(); chk("R11 combined", flag_acc, 8'hB0);
        wr(4'd9, 8'h80);
        tick_run(1'b1); mstep(); chk("R10 one top bit not dont care", flag_acc, 8'h90);
        bin_mode = 1'b0;
        load(44, 15, 8, 1, 1, 1, 1);
        wr(4'd8, 8'h45); wr(4'd9, 8'hC0); wr(4'd10, 8'hC0); upd_ie = 1'b0;
        tick_run(1'b1); mstep(); chk("R10 bcd alarm", flag_acc, 8'hA0);
        alarm_ie = 1'b0; bin_mode = 1'b1;

        // random times, all formats
        for (int it = 0; it < 60; it++) begin
            int s, m, h, w, d, mth, y;
            bin_mode = 1'($urandom_range(0, 1));
            h24_mode = 1'($urandom_range(0, 1));
            y   = $urandom_range(0, 99);
            mth = $urandom_range(1, 12);
            d   = ($urandom_range(0, 1) == 1) ? bdim(mth, y) : $urandom_range(1, bdim(mth, y));
            h   = ($urandom_range(0, 1) == 1) ? 23 : $urandom_range(0, 23);
            m   = ($urandom_range(0, 1) == 1) ? 59 : $urandom_range(0, 59);
            s   = ($urandom_range(0, 3) != 0) ? 59 : $urandom_range(0, 59);
            w   = $urandom_range(0, 6);
            load(s, m, h, w, d, mth, y);
            tick_run(1'b1); mstep(); check_time("R3 R5 R6 random");
        end

        done = 1'b1;
        $display("%0d/%0d checks passed", total - fails, total);
        $finish;
    end
endmodule